// File: doc/BRIEF.md
# Memory Branch State Register

This block holds the 8-bit state code that software reads to find out how far a memory branch has got through bring-up and through recovery of a mirrored pair. One code covers the whole branch, whether it runs one channel or two. Configuration software or a sequencer writes the code through a software write port. Each software write is checked against the set of legal codes and against the current mirroring mode. A write that fails the check is dropped, and a one-cycle reject flag tells the writer.

Internal hardware has a separate privileged update port. It skips the mode and write-protection rules, so hardware can record a loss of redundancy. It still loads only legal codes. There are two synchronous active-high resets. Power-on reset always clears the code. Hard reset clears it only when the sticky-enable input is low. The choice of which state comes next is made outside this block.

Top module: `brstate_reg`

## Requirements
- R1: While `por` is high at a clock edge, `state_q` becomes 00h and `wr_reject` becomes 0, whatever `sticky_en` is. Power-on reset has the highest priority.
- R2: While `hard_rst` is high and `por` is low at a clock edge, with `sticky_en` low, `state_q` becomes 00h and `wr_reject` becomes 0.
- R3: While `hard_rst` is high and `por` is low at a clock edge, with `sticky_en` high, `state_q` keeps its value. Both write ports are ignored, and `wr_reject` becomes 0.
- R4: A software write (`sw_wr_en`=1) of one of the codes 00h, 10h, 20h, 30h, 40h, 50h, B0h, C0h or D0h loads that code into `state_q` at the next clock edge.
- R5: The recovery codes 70h, 80h and 90h are loaded from the software port only while `mirror_en` is 1. When `mirror_en` is 0 they are rejected.
- R6: A software write of 60h (redundancy lost) is always rejected.
- R7: A software write of a code whose low nibble is nonzero, or whose upper nibble is A, E or F, is rejected.
- R8: A rejected software write leaves `state_q` unchanged, except when a hardware update loads it in the same cycle. It drives `wr_reject` high for exactly the one cycle after the write edge.
- R9: A hardware update (`hw_wr_en`=1) loads any legal code, including 60h and the recovery codes, whatever `mirror_en` is. A hardware update with a code that is not legal is ignored and raises no flag.
- R10: When a legal hardware update and a software write arrive in the same cycle, the hardware code is loaded and the software write is flagged as rejected.
- R11: In a cycle with no software write, `wr_reject` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| hard_rst | input | 1 | Hard reset, synchronous, active high |
| sticky_en | input | 1 | When 1, the code survives a hard reset |
| mirror_en | input | 1 | Mirroring mode; allows software to write recovery codes |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 8 | Software write code |
| hw_wr_en | input | 1 | Privileged hardware update strobe |
| hw_wr_data | input | 8 | Privileged hardware update code |
| state_q | output | 8 | Current branch state code |
| wr_reject | output | 1 | One-cycle pulse after a rejected software write |

## Verification
The assertions assume that both resets are synchronous and sampled on `clk`. They also assume that `mirror_en` and `sticky_en` are settled before the edge that uses them. No assertion depends on how often the ports are strobed. The stimulus changes every input only on the falling clock edge. It starts with a power-on reset, so no property sees values from before the first reset. The random data is weighted toward legal codes. This way, accepted writes, recovery writes with and without mirroring, and port collisions all occur often next to the illegal codes.

// File: rtl/brstate_pkg.sv
package brstate_pkg;

    localparam int CODE_W = 8;
    localparam int NIB_W  = CODE_W / 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [CODE_W-1:0] {
        ST_RESET      = 8'h00,
        ST_INIT       = 8'h10,
        ST_READY      = 8'h20,
        ST_ACTIVE     = 8'h30,
        ST_REDUNDANT  = 8'h40,
        ST_DISABLED   = 8'h50,
        ST_REDUN_LOST = 8'h60,
        ST_RCV_RESET  = 8'h70,
        ST_RCV_INIT   = 8'h80,
        ST_RCV_READY  = 8'h90,
        ST_RCV_FAULT  = 8'hB0,
        ST_RCV_FAILED = 8'hC0,
        ST_FAULT      = 8'hD0
    } br_state_e;

    // Write classes a code can fall into
    typedef enum logic [1:0] {
        CLS_PLAIN,     // any writer may load it
        CLS_RECOVERY,  // software only while mirroring is on
        CLS_HWONLY,    // privileged port only
        CLS_INVALID    // nobody may load it
    } code_class_e;

    typedef struct packed {
        logic  en;
        code_t data;
    } wr_req_t;

    typedef struct packed {
        logic  load;
        code_t data;
        logic  reject;
    } wr_decision_t;

    function automatic code_class_e classify(input code_t c);
        code_class_e cls;
        if (c[NIB_W-1:0] != '0) begin
            cls = CLS_INVALID;
        end else begin
            unique case (c[CODE_W-1:NIB_W])
                4'h0, 4'h1, 4'h2, 4'h3,
                4'h4, 4'h5, 4'hB, 4'hC, 4'hD: cls = CLS_PLAIN;
                4'h6:                         cls = CLS_HWONLY;
                4'h7, 4'h8, 4'h9:             cls = CLS_RECOVERY;
                default:                      cls = CLS_INVALID;
            endcase
        end
        return cls;
    endfunction

endpackage

// File: rtl/brstate_filter.sv
module brstate_filter
    import brstate_pkg::*;
(
    input  wr_req_t      sw_req,
    input  wr_req_t      hw_req,
    input  logic         mirror_en,
    output wr_decision_t decision
);
    code_class_e sw_cls;
    code_class_e hw_cls;
    logic        sw_ok;
    logic        hw_ok;

    always_comb begin
        sw_cls = classify(sw_req.data);
        hw_cls = classify(hw_req.data);

        hw_ok = hw_req.en && (hw_cls != CLS_INVALID);
        sw_ok = sw_req.en &&
                ((sw_cls == CLS_PLAIN) ||
                 ((sw_cls == CLS_RECOVERY) && mirror_en));

        decision = '0;
        if (hw_ok) begin
            decision.load = 1'b1;
            decision.data = hw_req.data;
        end else if (sw_ok) begin
            decision.load = 1'b1;
            decision.data = sw_req.data;
        end
        decision.reject = sw_req.en && (!sw_ok || hw_ok);
    end
endmodule

// File: rtl/brstate_store.sv
module brstate_store
    import brstate_pkg::*;
(
    input  logic         clk,
    input  logic         por,
    input  logic         hard_rst,
    input  logic         sticky_en,
    input  wr_decision_t decision,
    output code_t        state_q,
    output logic         wr_reject
);
    always_ff @(posedge clk) begin
        if (por) begin
            state_q   <= ST_RESET;
            wr_reject <= 1'b0;
        end else if (hard_rst) begin
            if (!sticky_en) begin
                state_q <= ST_RESET;
            end
            wr_reject <= 1'b0;
        end else begin
            if (decision.load) begin
                state_q <= decision.data;
            end
            wr_reject <= decision.reject;
        end
    end
endmodule

// File: rtl/brstate_reg.sv
module brstate_reg
    import brstate_pkg::*;
(
    input  logic              clk,
    input  logic              por,
    input  logic              hard_rst,
    input  logic              sticky_en,
    input  logic              mirror_en,
    input  logic              sw_wr_en,
    input  logic [CODE_W-1:0] sw_wr_data,
    input  logic              hw_wr_en,
    input  logic [CODE_W-1:0] hw_wr_data,
    output logic [CODE_W-1:0] state_q,
    output logic              wr_reject
);
    wr_req_t      sw_req;
    wr_req_t      hw_req;
    wr_decision_t decision;

    assign sw_req = '{en: sw_wr_en, data: sw_wr_data};
    assign hw_req = '{en: hw_wr_en, data: hw_wr_data};

    brstate_filter u_filter (
        .sw_req    (sw_req),
        .hw_req    (hw_req),
        .mirror_en (mirror_en),
        .decision  (decision)
    );

    brstate_store u_store (
        .clk       (clk),
        .por       (por),
        .hard_rst  (hard_rst),
        .sticky_en (sticky_en),
        .decision  (decision),
        .state_q   (state_q),
        .wr_reject (wr_reject)
    );
endmodule

// File: rtl/brstate_checks.sv
module brstate_checks
    import brstate_pkg::*;
(
    input logic              clk,
    input logic              por,
    input logic              hard_rst,
    input logic              sticky_en,
    input logic              mirror_en,
    input logic              sw_wr_en,
    input logic [CODE_W-1:0] sw_wr_data,
    input logic              hw_wr_en,
    input logic [CODE_W-1:0] hw_wr_data,
    input logic [CODE_W-1:0] state_q,
    input logic              wr_reject
);
    logic sw_is_recovery;
    assign sw_is_recovery = (sw_wr_data == 8'h70) || (sw_wr_data == 8'h80) ||
                            (sw_wr_data == 8'h90);

    a_r1_por_clears: assert property (@(posedge clk)
        por |=> (state_q == 8'h00) && !wr_reject);

    a_r2_hard_nonsticky: assert property (@(posedge clk) disable iff (por)
        (hard_rst && !sticky_en) |=> (state_q == 8'h00) && !wr_reject);

    a_r3_sticky_hold: assert property (@(posedge clk) disable iff (por)
        (hard_rst && sticky_en) |=> $stable(state_q) && !wr_reject);

    a_r5_no_rcv_unmirrored: assert property (@(posedge clk) disable iff (por)
        (!hard_rst && !hw_wr_en && sw_wr_en && sw_is_recovery && !mirror_en)
            |=> $stable(state_q) && wr_reject);

    a_r6_no_sw_lost: assert property (@(posedge clk) disable iff (por)
        (!hw_wr_en && state_q != 8'h60) |=> (state_q != 8'h60));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (por)
        (state_q[3:0] == 4'h0) && (state_q[7:4] != 4'hA) &&
        (state_q[7:4] != 4'hE) && (state_q[7:4] != 4'hF));

    a_r8_reject_keeps: assert property (@(posedge clk) disable iff (por)
        (wr_reject && !$past(hw_wr_en)) |-> $stable(state_q));

    a_r11_idle_no_flag: assert property (@(posedge clk) disable iff (por)
        !sw_wr_en |=> !wr_reject);
endmodule

bind brstate_reg brstate_checks u_chk (.*);

// File: tb/tb_brstate_reg.sv
module tb_brstate_reg;
    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       hard_rst = 1'b0;
    logic       sticky_en = 1'b0;
    logic       mirror_en = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic [7:0] sw_wr_data = 8'h00;
    logic       hw_wr_en = 1'b0;
    logic [7:0] hw_wr_data = 8'h00;
    logic [7:0] state_q;
    logic       wr_reject;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    logic [7:0] exp_state = 8'h00;
    logic       exp_rej = 1'b0;

    always #10 clk = ~clk;

    brstate_reg dut (
        .clk(clk), .por(por), .hard_rst(hard_rst), .sticky_en(sticky_en),
        .mirror_en(mirror_en), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .hw_wr_en(hw_wr_en), .hw_wr_data(hw_wr_data),
        .state_q(state_q), .wr_reject(wr_reject)
    );

    function automatic bit legal(input logic [7:0] c);
        return (c[3:0] == 4'h0) && (c[7:4] <= 4'hD) && (c[7:4] != 4'hA);
    endfunction

    function automatic bit recov(input logic [7:0] c);
        return (c == 8'h70) || (c == 8'h80) || (c == 8'h90);
    endfunction

    function automatic bit sw_allowed(input logic [7:0] c, input logic mir);
        return legal(c) && (c != 8'h60) && (!recov(c) || mir);
    endfunction

    function automatic string tag_of();
        if (por)                         return "R1";
        if (hard_rst)                    return sticky_en ? "R3" : "R2";
        if (hw_wr_en && sw_wr_en && legal(hw_wr_data)) return "R10";
        if (hw_wr_en)                    return "R9";
        if (!sw_wr_en)                   return "R11";
        if (!legal(sw_wr_data))          return "R7";
        if (sw_wr_data == 8'h60)         return "R6";
        if (recov(sw_wr_data))           return "R5";
        return "R4";
    endfunction

    task automatic model_update();
        bit hw_ok;
        bit sw_ok;
        if (por) begin
            exp_state = 8'h00;
            exp_rej   = 1'b0;
        end else if (hard_rst) begin
            if (!sticky_en) exp_state = 8'h00;
            exp_rej = 1'b0;
        end else begin
            hw_ok = hw_wr_en && legal(hw_wr_data);
            sw_ok = sw_wr_en && sw_allowed(sw_wr_data, mirror_en);
            if (hw_ok)      exp_state = hw_wr_data;
            else if (sw_ok) exp_state = sw_wr_data;
            exp_rej = sw_wr_en && (!sw_ok || hw_ok);
        end
    endtask

    task automatic step(input logic p, input logic h, input logic st,
                        input logic m, input logic swe, input logic [7:0] swd,
                        input logic hwe, input logic [7:0] hwd);
        string tag;
        por = p; hard_rst = h; sticky_en = st; mirror_en = m;
        sw_wr_en = swe; sw_wr_data = swd; hw_wr_en = hwe; hw_wr_data = hwd;
        tag = tag_of();
        @(posedge clk);
        model_update();
        @(negedge clk);
        checks++;
        if (state_q !== exp_state || wr_reject !== exp_rej) begin
            fails++;
            $display("FAIL %s: state_q=%h wr_reject=%b expected state_q=%h wr_reject=%b",
                     tag, state_q, wr_reject, exp_state, exp_rej);
        end
    endtask

    function automatic logic [7:0] pick_code();
        int r = int'($urandom_range(0, 9));
        if (r < 7) return {4'($urandom_range(0, 13)), 4'h0};
        return 8'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: power-on reset state
        step(1, 0, 0, 0, 0, 8'h00, 0, 8'h00);
        // R4: plain codes accepted
        step(0, 0, 0, 0, 1, 8'h30, 0, 8'h00);
        step(0, 0, 0, 0, 1, 8'hD0, 0, 8'h00);
        // R6: redundancy-lost code refused from software
        step(0, 0, 0, 1, 1, 8'h60, 0, 8'h00);
        // R8: flag lasts one cycle
        step(0, 0, 0, 0, 0, 8'h00, 0, 8'h00);
        // R7: reserved and malformed codes
        step(0, 0, 0, 1, 1, 8'hA0, 0, 8'h00);
        step(0, 0, 0, 1, 1, 8'h15, 0, 8'h00);
        step(0, 0, 0, 1, 1, 8'hF0, 0, 8'h00);
        // R5: recovery codes need mirroring
        step(0, 0, 0, 0, 1, 8'h80, 0, 8'h00);
        step(0, 0, 0, 1, 1, 8'h80, 0, 8'h00);
        // R9: privileged port loads 60h, ignores A0h
        step(0, 0, 0, 0, 0, 8'h00, 1, 8'h60);
        step(0, 0, 0, 0, 0, 8'h00, 1, 8'hA0);
        step(0, 0, 0, 0, 0, 8'h00, 1, 8'h90);
        // R10: collision, hardware wins
        step(0, 0, 0, 0, 1, 8'h20, 1, 8'h40);
        // R3: sticky hard reset keeps value, writes ignored
        step(0, 1, 1, 0, 1, 8'h10, 1, 8'h50);
        // R2: non-sticky hard reset clears
        step(0, 1, 0, 0, 0, 8'h00, 0, 8'h00);
        step(0, 0, 0, 0, 1, 8'hC0, 0, 8'h00);
        // R1: power-on reset clears even when sticky
        step(1, 0, 1, 0, 0, 8'h00, 0, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 99) < 2, $urandom_range(0, 99) < 5,
                 1'($urandom), 1'($urandom),
                 $urandom_range(0, 99) < 70, pick_code(),
                 $urandom_range(0, 99) < 15, pick_code());
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule